// File: doc/BRIEF.md
# I2C Command/Status Bus Master

This block is a single-master I2C controller run from one shared command/status register. Software loads a target address byte (seven address bits plus a direction bit) and, for writes, a data byte, then writes a command word to the command/status offset. A command runs one byte cycle on the bus. It can open with a START or a repeated START, it always carries the address byte when it opens one, and it closes either with a STOP or by holding SCL low so that the next command can carry on.

A read at the same offset returns transfer and bus status rather than the last command. The two acknowledge-error flags clear themselves when the status is read. In receive mode the master answers each byte with ACK or NACK, as chosen by the command. When a command finishes or is aborted by a NACK, the interrupt output is raised. SCL and SDA are open-drain: each line has an output-enable that pulls it low and a separate input that returns the resolved bus level.

Register offsets on `addr_i`: 0 = target address byte (bits 7:1 address, bit 0 direction, 1 = read); 1 = command (write) / status (read); 2 = data byte.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, the status read returns 0x00000020, `scl_oe_o` and `sda_oe_o` are 0, and `irq_o` is 0.
- R2: Status bits are: bit0 BUSY, bit1 ERROR, bit2 ADRACK (address NACK), bit3 DATACK (data NACK), bit4 ARBLST, bit5 IDLE, bit6 BUSBSY, bit7 CLKTO. Bits 31:8, ARBLST and CLKTO read 0. ERROR equals ADRACK OR DATACK.
- R3: Command bits are bit0 RUN, bit1 START, bit2 STOP, bit3 ACK. A write of 0x7 with direction 0 produces START, the address byte MSB first, the data byte, then STOP. BUSY reads 1 (and IDLE 0) right after the command is written.
- R4: A read transfer (direction 1) with ACK=0 shifts in one byte MSB first and answers it with NACK. The byte is then readable at offset 2.
- R5: A receive command with ACK=1 and STOP=0 answers the byte with ACK and then holds SCL low. Status reads 0x40 in this held state (BUSY 0, IDLE 0, BUSBSY 1).
- R6: A START=1 command issued while the bus is held produces a repeated START with no STOP in between. The new direction bit applies.
- R7: A START=0 command issued while the bus is held runs only a data byte, with no START and no address byte.
- R8: If the address byte is not acknowledged, the block sets ADRACK and ERROR, issues STOP and returns to IDLE.
- R9: If a transmitted data byte is not acknowledged, the block sets DATACK and ERROR, issues STOP and returns to IDLE.
- R10: A status read clears ADRACK, DATACK and with them ERROR; the next status read no longer shows them.
- R11: `irq_o` rises when a command completes (STOP finished or bus held) or aborts, and falls after a status read.
- R12: A command write with RUN=0 causes no bus activity and leaves the status unchanged.
- R13: During a transfer, SDA changes only while SCL is low, except at START and STOP. BUSBSY is 1 from a START on the bus until the following STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (clears acknowledge flags and interrupt when reading status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Completion/abort interrupt |
| scl_i | input | 1 | Resolved SCL level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Resolved SDA level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with a quarter-period divider of 4 system clocks, so one SCL bit lasts 16 cycles. This keeps dozens of complete transfers, chained holds and repeated STARTs within a short run, and a behavioural target on the bus can still react between SCL edges. The target's address match, its choice of ACK for written data, and the bytes it returns are varied, which brings both NACK abort paths and the clear-on-read of the flags into reach.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] OFS_TADDR = 2'd0;
  localparam logic [1:0] OFS_CTRL  = 2'd1;
  localparam logic [1:0] OFS_DATA  = 2'd2;

  localparam int CMD_RUN   = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_ACK   = 3;

  typedef enum logic [2:0] {
    EN_IDLE, EN_START, EN_ADDR, EN_DATA, EN_STOP, EN_HOLD
  } eng_state_e;

  typedef struct packed {
    logic clk_to;
    logic bus_bsy;
    logic idle;
    logic arb_lost;
    logic dat_nack;
    logic adr_nack;
    logic error;
    logic busy;
  } stat_t;
endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int QTR_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  if (QTR_CYC <= 1) begin : g_every
    assign tick_o = 1'b1;
  end else begin : g_div
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (cnt_q == CW'(QTR_CYC - 1)) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
    assign tick_o = (cnt_q == CW'(QTR_CYC - 1));
  end
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_bsy_o
);
  logic scl_q, sda_q, start_det, stop_det, bsy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bsy_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) bsy_q <= 1'b1;
      else if (stop_det) bsy_q <= 1'b0;
    end
  end

  assign start_det = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;
  assign bus_bsy_o = bsy_q;

  // R13
  bus_bsy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_i) && scl_i && $past(scl_i)) |=> bus_bsy_o);
endmodule

// File: rtl/i2c_xfer_eng.sv
module i2c_xfer_eng
  import i2c_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       go_i,
  input  logic       cmd_start_i,
  input  logic       cmd_stop_i,
  input  logic       cmd_ack_i,
  input  logic [7:0] taddr_i,
  input  logic [7:0] tx_byte_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       idle_o,
  output logic       done_o,
  output logic       adr_nack_o,
  output logic       dat_nack_o,
  output logic       rx_vld_o,
  output logic [7:0] rx_byte_o
);
  eng_state_e state_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rw_q, stop_q, ack_q, nack_q;
  logic       done_q, adr_q, dat_q, rxv_q;
  logic       accept, m_drive;

  assign accept = go_i && (state_q == EN_IDLE || state_q == EN_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EN_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      stop_q  <= 1'b0;
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
      adr_q   <= 1'b0;
      dat_q   <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      adr_q  <= 1'b0;
      dat_q  <= 1'b0;
      rxv_q  <= 1'b0;
      if (accept) begin
        stop_q <= cmd_stop_i;
        ack_q  <= cmd_ack_i;
        ph_q   <= '0;
        if (state_q == EN_IDLE || cmd_start_i) begin
          state_q <= EN_START;
        end else begin
          state_q <= EN_DATA;
          bit_q   <= '0;
          sh_q    <= rw_q ? 8'h00 : tx_byte_i;
        end
      end else if (tick_i && state_q != EN_IDLE && state_q != EN_HOLD) begin
        ph_q <= ph_q + 2'd1;
        unique case (state_q)
          EN_START: if (ph_q == 2'd3) begin
            state_q <= EN_ADDR;
            bit_q   <= '0;
            sh_q    <= taddr_i;
            rw_q    <= taddr_i[0];
          end
          EN_ADDR, EN_DATA: begin
            if (ph_q == 2'd1) begin
              if (bit_q == 4'd8) nack_q <= sda_i;
              else if (state_q == EN_DATA && rw_q) sh_q <= {sh_q[6:0], sda_i};
            end
            if (ph_q == 2'd3) begin
              if (bit_q != 4'd8) begin
                bit_q <= bit_q + 4'd1;
                if (!(state_q == EN_DATA && rw_q)) sh_q <= {sh_q[6:0], 1'b0};
              end else if (state_q == EN_ADDR) begin
                if (nack_q) begin
                  state_q <= EN_STOP;
                  adr_q   <= 1'b1;
                end else begin
                  state_q <= EN_DATA;
                  bit_q   <= '0;
                  sh_q    <= rw_q ? 8'h00 : tx_byte_i;
                end
              end else if (!rw_q && nack_q) begin
                state_q <= EN_STOP;
                dat_q   <= 1'b1;
              end else begin
                rxv_q   <= rw_q;
                state_q <= stop_q ? EN_STOP : EN_HOLD;
                done_q  <= !stop_q;
              end
            end
          end
          EN_STOP: if (ph_q == 2'd3) begin
            state_q <= EN_IDLE;
            done_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // master owns SDA for every address bit and for written data bits
  assign m_drive = (state_q == EN_ADDR) || !rw_q;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      EN_START: begin
        scl_oe_o = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_oe_o = ph_q[1];
      end
      EN_ADDR, EN_DATA: begin
        scl_oe_o = (ph_q == 2'd0) || (ph_q == 2'd3);
        if (bit_q != 4'd8) sda_oe_o = m_drive & ~sh_q[7];
        else sda_oe_o = (state_q == EN_DATA) && rw_q && ack_q;
      end
      EN_STOP: begin
        scl_oe_o = (ph_q == 2'd0);
        sda_oe_o = !ph_q[1];
      end
      EN_HOLD: scl_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o     = (state_q != EN_IDLE) && (state_q != EN_HOLD);
  assign idle_o     = (state_q == EN_IDLE);
  assign done_o     = done_q;
  assign adr_nack_o = adr_q;
  assign dat_nack_o = dat_q;
  assign rx_vld_o   = rxv_q;
  assign rx_byte_o  = sh_q;

  // R13
  sda_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == EN_ADDR || state_q == EN_DATA) && $past(state_q) == state_q
     && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  // R3
  go_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && idle_o) |=> busy_o);

  // R8
  adr_nack_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_nack_o |=> (busy_o && !done_o));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int QTR_CYC = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  input  logic             scl_i,
  output logic             scl_oe_o,
  input  logic             sda_i,
  output logic             sda_oe_o
);
  logic       tick, go, stat_rd;
  logic       busy, idle, done, adr_nack, dat_nack, rx_vld, bus_bsy;
  logic [7:0] rx_byte, taddr_q, data_q;
  logic       adrack_q, datack_q, irq_q;
  stat_t      stat;

  assign go      = wr_i && addr_i == OFS_CTRL && wdata_i[CMD_RUN];
  assign stat_rd = rd_i && addr_i == OFS_CTRL;

  i2c_qtr_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  i2c_bus_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i, .bus_bsy_o(bus_bsy)
  );

  i2c_xfer_eng u_eng (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .go_i        (go),
    .cmd_start_i (wdata_i[CMD_START]),
    .cmd_stop_i  (wdata_i[CMD_STOP]),
    .cmd_ack_i   (wdata_i[CMD_ACK]),
    .taddr_i     (taddr_q),
    .tx_byte_i   (data_q),
    .sda_i,
    .scl_oe_o, .sda_oe_o,
    .busy_o      (busy),
    .idle_o      (idle),
    .done_o      (done),
    .adr_nack_o  (adr_nack),
    .dat_nack_o  (dat_nack),
    .rx_vld_o    (rx_vld),
    .rx_byte_o   (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taddr_q  <= '0;
      data_q   <= '0;
      adrack_q <= 1'b0;
      datack_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_i && addr_i == OFS_TADDR) taddr_q <= wdata_i[7:0];
      if (rx_vld) data_q <= rx_byte;
      else if (wr_i && addr_i == OFS_DATA) data_q <= wdata_i[7:0];
      if (adr_nack) adrack_q <= 1'b1;
      else if (stat_rd) adrack_q <= 1'b0;
      if (dat_nack) datack_q <= 1'b1;
      else if (stat_rd) datack_q <= 1'b0;
      if (done) irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat.busy     = busy;
    stat.error    = adrack_q | datack_q;
    stat.adr_nack = adrack_q;
    stat.dat_nack = datack_q;
    stat.idle     = idle;
    stat.bus_bsy  = bus_bsy;
    unique case (addr_i)
      OFS_TADDR: rdata_o = {24'h0, taddr_q};
      OFS_CTRL:  rdata_o = {24'h0, stat};
      OFS_DATA:  rdata_o = {24'h0, data_q};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R10
  ack_flags_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !adr_nack && !dat_nack) |=> !(adrack_q || datack_q));

  // R11
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> irq_o);
endmodule

// File: tb/i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  localparam int QTR = 4;
  localparam logic [6:0] TGT = 7'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, scl_oe, sda_oe, scl, sda;

  int n_chk = 0, n_fail = 0;

  // target model state
  logic       s_oe = 1'b0, p_scl = 1'b1, p_sda = 1'b1, act = 1'b0, rw = 1'b0, m_ack = 1'b0;
  logic [1:0] kind = '0;
  logic [3:0] bitn = '0;
  logic [7:0] sh = '0, wbyte = '0, txb = '0;
  logic       ack_data = 1'b1;
  logic [7:0] tx_base = 8'h00;
  int         rd_idx = 0, starts = 0, stops = 0, wcnt = 0, mack_cnt = 0, mnack_cnt = 0;

  always #10 clk = ~clk;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | s_oe);

  i2c_cmd_master #(.QTR_CYC(QTR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .scl_i(scl), .scl_oe_o(scl_oe), .sda_i(sda), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] slv_byte(input logic [7:0] base, input int idx);
    return base + 8'(idx * 8'h5B);
  endfunction

  function automatic logic [31:0] exp_stat(input logic busy, input logic adr,
                                           input logic dat, input logic idle,
                                           input logic bb);
    return {24'h0, 1'b0, bb, idle, 1'b0, dat, adr, adr | dat, busy};
  endfunction

  // behavioural target: samples the bus each system clock
  always @(posedge clk) begin
    logic [7:0] nb;
    p_scl <= scl;
    p_sda <= sda;
    if (p_scl && scl && p_sda && !sda) begin
      starts <= starts + 1;
      act <= 1'b1; kind <= 2'd0; bitn <= '0; s_oe <= 1'b0; rd_idx <= 0;
    end else if (p_scl && scl && !p_sda && sda) begin
      stops <= stops + 1;
      act <= 1'b0; s_oe <= 1'b0;
    end else if (act) begin
      if (!p_scl && scl) begin
        if (bitn < 8 && kind != 2'd2) sh <= {sh[6:0], sda};
        if (bitn == 8 && kind == 2'd2) m_ack <= !sda;
        bitn <= bitn + 4'd1;
      end else if (p_scl && !scl) begin
        if (bitn == 8) begin
          if (kind == 2'd0) begin
            if (sh[7:1] == TGT) begin s_oe <= 1'b1; rw <= sh[0]; end
            else begin s_oe <= 1'b0; act <= 1'b0; end
          end else if (kind == 2'd1) begin
            wbyte <= sh; wcnt <= wcnt + 1; s_oe <= ack_data;
          end else s_oe <= 1'b0;
        end else if (bitn == 9) begin
          bitn <= '0;
          if (kind == 2'd0) begin
            if (rw) begin
              nb = slv_byte(tx_base, 0);
              kind <= 2'd2; txb <= nb; s_oe <= ~nb[7]; rd_idx <= 1;
            end else begin
              kind <= 2'd1; s_oe <= 1'b0;
            end
          end else if (kind == 2'd2) begin
            if (m_ack) begin
              nb = slv_byte(tx_base, rd_idx);
              mack_cnt <= mack_cnt + 1;
              txb <= nb; s_oe <= ~nb[7]; rd_idx <= rd_idx + 1;
            end else begin
              mnack_cnt <= mnack_cnt + 1;
              kind <= 2'd3; s_oe <= 1'b0;
            end
          end else s_oe <= 1'b0;
        end else if (kind == 2'd2 && bitn >= 1 && bitn <= 7) begin
          s_oe <= ~txb[4'd7 - bitn];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (irq !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " irq"}, 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int s0, p0, w0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 layout
    rd_reg(2'd1, r);
    chk("R1 status", r, 32'h20);
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 irq", 32'(irq), 0);

    // R12 RUN=0
    wr_reg(2'd1, 32'hE);
    repeat (200) @(negedge clk);
    chk("R12 no start", 32'(starts), 0);
    rd_reg(2'd1, r);
    chk("R12 status", r, 32'h20);

    // R3 single write
    wr_reg(2'd0, {24'h0, TGT, 1'b0});
    wr_reg(2'd2, 32'hA5);
    wr_reg(2'd1, 32'h7);
    rd_reg(2'd1, r);
    chk("R3 busy", r, exp_stat(1, 0, 0, 0, 0));
    wait_irq("R3");
    chk("R3 byte", 32'(wbyte), 32'hA5);
    chk("R13 starts", 32'(starts), 1);
    chk("R13 stops", 32'(stops), 1);
    rd_reg(2'd1, r);
    chk("R2 status done", r, 32'h20);
    chk("R11 irq cleared", 32'(irq), 0);

    // R4 read with NACK
    tx_base = 8'h3C;
    wr_reg(2'd0, {24'h0, TGT, 1'b1});
    wr_reg(2'd1, 32'h7);
    wait_irq("R4");
    rd_reg(2'd2, r);
    chk("R4 data", r, 32'(slv_byte(8'h3C, 0)));
    chk("R4 nack", 32'(mnack_cnt), 1);
    rd_reg(2'd1, r);

    // R5 receive with ACK, hold; R7 continue without START
    tx_base = 8'hC3;
    s0 = starts;
    wr_reg(2'd1, 32'hB);
    wait_irq("R5");
    rd_reg(2'd1, r);
    chk("R5 hold status", r, exp_stat(0, 0, 0, 0, 1));
    chk("R5 scl held", 32'(scl_oe), 1);
    chk("R5 master ack", 32'(mack_cnt), 1);
    rd_reg(2'd2, r);
    chk("R5 data", r, 32'(slv_byte(8'hC3, 0)));
    wr_reg(2'd1, 32'h5);
    wait_irq("R7");
    rd_reg(2'd2, r);
    chk("R7 data", r, 32'(slv_byte(8'hC3, 1)));
    chk("R7 no start", 32'(starts - s0), 1);
    rd_reg(2'd1, r);
    chk("R7 status", r, 32'h20);

    // R6 write, hold, repeated START into read
    s0 = starts; p0 = stops;
    tx_base = 8'h71;
    wr_reg(2'd0, {24'h0, TGT, 1'b0});
    wr_reg(2'd2, 32'h5E);
    wr_reg(2'd1, 32'h3);
    wait_irq("R6");
    rd_reg(2'd1, r);
    chk("R6 held", r, 32'h40);
    chk("R6 byte", 32'(wbyte), 32'h5E);
    wr_reg(2'd0, {24'h0, TGT, 1'b1});
    wr_reg(2'd1, 32'h7);
    wait_irq("R6");
    rd_reg(2'd2, r);
    chk("R6 read data", r, 32'(slv_byte(8'h71, 0)));
    chk("R6 starts", 32'(starts - s0), 2);
    chk("R6 stops", 32'(stops - p0), 1);
    rd_reg(2'd1, r);

    // R8 address NACK, R10 clear on read
    p0 = stops;
    wr_reg(2'd0, {24'h0, 7'h15, 1'b0});
    wr_reg(2'd1, 32'h7);
    wait_irq("R8");
    rd_reg(2'd1, r);
    chk("R8 adrack", r, exp_stat(0, 1, 0, 1, 0));
    chk("R8 stop", 32'(stops - p0), 1);
    rd_reg(2'd1, r);
    chk("R10 adrack cleared", r, 32'h20);

    // R9 data NACK
    ack_data = 1'b0;
    w0 = wcnt;
    wr_reg(2'd0, {24'h0, TGT, 1'b0});
    wr_reg(2'd2, 32'h99);
    wr_reg(2'd1, 32'h7);
    wait_irq("R9");
    rd_reg(2'd1, r);
    chk("R9 datack", r, exp_stat(0, 0, 1, 1, 0));
    chk("R9 byte seen", 32'(wcnt - w0), 1);
    rd_reg(2'd1, r);
    chk("R10 datack cleared", r, 32'h20);
    ack_data = 1'b1;

    // random single transfers (R3, R4)
    for (int i = 0; i < 12; i++) begin
      logic dir;
      logic [7:0] d;
      dir = 1'($urandom);
      d = 8'($urandom);
      tx_base = 8'($urandom);
      wr_reg(2'd0, {24'h0, TGT, dir});
      wr_reg(2'd2, {24'h0, d});
      wr_reg(2'd1, 32'h7);
      wait_irq(dir ? "R4 rand" : "R3 rand");
      if (dir) begin
        rd_reg(2'd2, r);
        chk("R4 rand data", r, 32'(slv_byte(tx_base, 0)));
      end else begin
        chk("R3 rand byte", 32'(wbyte), 32'(d));
      end
      rd_reg(2'd1, r);
      chk("R2 rand status", r, 32'h20);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule